// File: doc/BRIEF.md
# Rewindable Synchronous FIFO with Half-Full Flag

This block is a single-clock FIFO controller wrapped around a dual-port storage array of 9-bit words. A producer raises a write request with a data word. A consumer raises a read request and receives the oldest stored word on the next clock, marked by a one-cycle valid pulse. Three active-low flags report the fill level: empty, full and more-than-half-full. The depth is a power-of-two parameter of at least 4.

Two coincident cases are handled without a stall. A read held on an empty FIFO together with a write passes the new word straight to the output. A write held on a full FIFO together with a read is stored into the slot that the read frees. A rewind request moves the read pointer back to storage location zero and keeps the write pointer. The stored data can then be read out again, as long as fewer than depth writes have happened since reset.

The controller is a four-state machine:
- `ST_EMPTY`: nothing stored.
- `ST_MID`: partly filled.
- `ST_FULL`: every location holds a word.
- `ST_REWIND`: a one-cycle settling state entered after a rewind.

Transitions:
- `ST_EMPTY` goes to `ST_MID` on a write without a read.
- `ST_MID` goes to `ST_EMPTY` when the count reaches zero, to `ST_FULL` when it reaches the depth, and otherwise stays.
- `ST_FULL` goes to `ST_MID` on a read without a write.
- Any state goes to `ST_REWIND` on a rewind request.
- `ST_REWIND` leaves to whichever of the three level states matches the recomputed count.

Top module: `fifo_rt`

## Requirements
- R1: While reset is low and on the first cycle after it, the outputs are empty_n=0, full_n=1, half_n=1, rd_valid=0 and rd_data=0.
- R2: A write without a read is ignored while full. A read without a write is ignored while empty and leaves the read pointer where it was.
- R3: empty_n is low exactly when the occupancy is 0, and full_n is low exactly when the occupancy equals DEPTH. Each flag updates on the clock edge that accepts the operation. The two are never low together.
- R4: half_n goes low on the write that lifts the occupancy from DEPTH/2 to DEPTH/2+1. It returns high only on the read that brings the occupancy back to exactly DEPTH/2. While full, half_n is low.
- R5: A rewind request sets the read pointer to 0, keeps the write pointer, and recomputes the occupancy as the write pointer value. All three flags are re-evaluated on that same edge. Read and write requests are ignored in the rewind cycle and in the following cycle.
- R6: While empty, a read and a write in the same cycle pass the written word to rd_data with rd_valid high on the next cycle. The FIFO stays empty.
- R7: While full, a read and a write in the same cycle return the oldest word and store the new word. The FIFO stays full.
- R8: rd_valid is high for exactly one cycle after each accepted read. rd_data changes only then and otherwise holds its value. Words leave in write order.
- R9: A read and a write in the same cycle with 0 < occupancy < DEPTH leave the occupancy and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_req | input | 1 | Write request |
| wr_data | input | DW (9) | Word to store |
| rd_req | input | 1 | Read request |
| rewind_req | input | 1 | Rewind the read pointer to location zero |
| rd_data | output | DW (9) | Last word read, held between reads |
| rd_valid | output | 1 | One-cycle pulse marking a new word on rd_data |
| empty_n | output | 1 | Low when nothing is stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |

## Verification
Every output is registered. The result of a request sampled on one rising edge is therefore visible right after that edge: rd_valid, rd_data and all three flags, including the flags recomputed by a rewind. The one exception is the cycle after a rewind, in which requests produce no result at all. The bench applies each stimulus on a falling edge and compares the outputs on the following falling edge, half a cycle after the edge that produced them. Before applying the next stimulus, it confirms that ignored writes, reads and rewinds had no effect, by reading the FIFO back through the normal read port and watching the empty flag.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;

    // Controller states: three fill levels plus a one-cycle rewind settle state.
    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_MID    = 2'd1,
        ST_FULL   = 2'd2,
        ST_REWIND = 2'd3
    } fifo_st_e;

endpackage

// File: rtl/fifo_rt_store.sv
// Storage array: one synchronous write port, one combinational read port.
module fifo_rt_store #(
    parameter int DW    = 9,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] rd_arr [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [DW-1:0] cell_q;

        always_ff @(posedge clk) begin
            if (we && (waddr == AW'(g))) begin
                cell_q <= wdata;
            end
        end

        assign rd_arr[g] = cell_q;
    end

    assign rdata = rd_arr[raddr];

endmodule

// File: rtl/fifo_rt_level.sv
// Registered fill-level flags, computed from the next occupancy value.
module fifo_rt_level #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_d,
    output logic          empty_n,
    output logic          full_n,
    output logic          half_n
);

    localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_n <= 1'b0;
            full_n  <= 1'b1;
            half_n  <= 1'b1;
        end else begin
            empty_n <= (cnt_d != '0);
            full_n  <= (cnt_d != FULL_CNT);
            // Goes low above half; returns high only once the count is back at half.
            half_n  <= !(cnt_d > HALF_CNT);
        end
    end

endmodule

// File: rtl/fifo_rt_ctrl.sv
// Pointer, occupancy and acceptance control with the level state machine.
module fifo_rt_ctrl
    import fifo_rt_pkg::*;
#(
    parameter int DW    = 9,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    input  logic          rewind_req,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [AW-1:0] mem_raddr,
    output logic [CW-1:0] cnt_d,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    fifo_st_e      st_q, st_d;
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          blocked, rd_go, wr_go, pass_go;

    function automatic fifo_st_e level_of(input logic [CW-1:0] c);
        if (c == '0) begin
            return ST_EMPTY;
        end else if (c == FULL_CNT) begin
            return ST_FULL;
        end
        return ST_MID;
    endfunction

    // Acceptance: a coincident write unlocks a read on empty, and a
    // coincident read unlocks a write on full.
    always_comb begin
        blocked = rewind_req || (st_q == ST_REWIND);
        rd_go   = !blocked && rd_req && ((st_q != ST_EMPTY) || wr_req);
        wr_go   = !blocked && wr_req && ((st_q != ST_FULL) || rd_req);
        pass_go = rd_go && (st_q == ST_EMPTY);
    end

    always_comb begin
        if (rewind_req) begin
            cnt_d = {1'b0, wp_q};
        end else begin
            cnt_d = cnt_q + CW'(wr_go) - CW'(rd_go);
        end
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        if (rewind_req) begin
            st_d = ST_REWIND;
        end else begin
            unique case (st_q)
                ST_EMPTY:  st_d = (wr_go && !rd_go) ? ST_MID : ST_EMPTY;
                ST_MID:    st_d = level_of(cnt_d);
                ST_FULL:   st_d = (rd_go && !wr_go) ? ST_MID : ST_FULL;
                ST_REWIND: st_d = level_of(cnt_q);
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (rewind_req) begin
                rp_q <= '0;
            end else begin
                if (wr_go) begin
                    wp_q <= wp_q + AW'(1);
                end
                if (rd_go) begin
                    rp_q <= rp_q + AW'(1);
                end
            end
        end
    end

    // Outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_go;
            if (rd_go) begin
                rd_data <= pass_go ? wr_data : mem_rdata;
            end
        end
    end

    assign mem_we    = wr_go;
    assign mem_waddr = wp_q;
    assign mem_raddr = rp_q;

endmodule

// File: rtl/fifo_rt.sv
// Top level: controller, storage array and flag register.
module fifo_rt #(
    parameter int DW    = 9,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    input  logic          rewind_req,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          empty_n,
    output logic          full_n,
    output logic          half_n
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic          mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [DW-1:0] mem_rdata;
    logic [CW-1:0] cnt_d;

    fifo_rt_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (wr_req),
        .wr_data    (wr_data),
        .rd_req     (rd_req),
        .rewind_req (rewind_req),
        .mem_rdata  (mem_rdata),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_raddr  (mem_raddr),
        .cnt_d      (cnt_d),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

    fifo_rt_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    fifo_rt_level #(.DEPTH(DEPTH)) u_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_d   (cnt_d),
        .empty_n (empty_n),
        .full_n  (full_n),
        .half_n  (half_n)
    );

endmodule

// File: rtl/fifo_rt_chk.sv
// Port-level properties, attached to every fifo_rt instance.
module fifo_rt_chk #(
    parameter int DW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_req,
    input logic [DW-1:0] wr_data,
    input logic          rd_req,
    input logic          rewind_req,
    input logic [DW-1:0] rd_data,
    input logic          rd_valid,
    input logic          empty_n,
    input logic          full_n,
    input logic          half_n
);

    AST_RESET_STATE: assert property (@(posedge clk)
        $rose(rst_n) |-> (!empty_n && full_n && half_n && !rd_valid)); // R1

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && rd_req && !wr_req) |=> !rd_valid); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && wr_req && !rd_req && !rewind_req) |=> !full_n); // R2

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!empty_n && !full_n)); // R3

    AST_FULL_IS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> !half_n); // R4

    AST_REWIND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rewind_req |=> !rd_valid); // R5

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && rd_req && wr_req && !rewind_req && !$past(rewind_req))
        |=> (rd_valid && !empty_n && (rd_data == $past(wr_data)))); // R6

    AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && rd_req && wr_req && !rewind_req && !$past(rewind_req))
        |=> (rd_valid && !full_n)); // R7

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_data)); // R8

endmodule

bind fifo_rt fifo_rt_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_req     (wr_req),
    .wr_data    (wr_data),
    .rd_req     (rd_req),
    .rewind_req (rewind_req),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .empty_n    (empty_n),
    .full_n     (full_n),
    .half_n     (half_n)
);

// File: tb/tb_fifo_rt.sv
module tb_fifo_rt;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int NVEC       = 8;

    typedef struct packed {
        logic       wr;
        logic [8:0] wd;
        logic       rd;
        logic       rt;
        logic       ev;
        logic [8:0] ed;
        logic       ee;
        logic       ef;
        logic       eh;
    } vec_t;

    // From reset: wr, wd, rd, rewind | valid, data, empty_n, full_n, half_n
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 9'h101, 1'b0, 1'b0, 1'b0, 9'h000, 1'b1, 1'b1, 1'b1},
        '{1'b1, 9'h0A2, 1'b0, 1'b0, 1'b0, 9'h000, 1'b1, 1'b1, 1'b1},
        '{1'b0, 9'h000, 1'b1, 1'b0, 1'b1, 9'h101, 1'b1, 1'b1, 1'b1},
        '{1'b1, 9'h033, 1'b1, 1'b0, 1'b1, 9'h0A2, 1'b1, 1'b1, 1'b1},
        '{1'b0, 9'h000, 1'b1, 1'b0, 1'b1, 9'h033, 1'b0, 1'b1, 1'b1},
        '{1'b0, 9'h000, 1'b1, 1'b0, 1'b0, 9'h033, 1'b0, 1'b1, 1'b1},
        '{1'b1, 9'h1C4, 1'b1, 1'b0, 1'b1, 9'h1C4, 1'b0, 1'b1, 1'b1},
        '{1'b0, 9'h000, 1'b0, 1'b0, 1'b0, 9'h1C4, 1'b0, 1'b1, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_req = 1'b0;
    logic [8:0] wr_data = '0;
    logic       rd_req = 1'b0;
    logic       rewind_req = 1'b0;
    logic [8:0] rd_data;
    logic       rd_valid, empty_n, full_n, half_n;

    int  n_run = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fifo_rt #(.DW(9), .DEPTH(DEPTH)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (wr_req),
        .wr_data    (wr_data),
        .rd_req     (rd_req),
        .rewind_req (rewind_req),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .empty_n    (empty_n),
        .full_n     (full_n),
        .half_n     (half_n)
    );

    task automatic check(input string req, input string what,
                         input logic [8:0] act, input logic [8:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge: apply inputs, pass one rising edge, return at
    // the next falling edge with the outputs settled.
    task automatic step(input logic w, input logic [8:0] d, input logic r, input logic t);
        wr_req = w; wr_data = d; rd_req = r; rewind_req = t;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_req = 1'b0; rd_req = 1'b0; rewind_req = 1'b0; wr_data = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic check_reset();
        check("R1", "empty_n", 9'(empty_n), 9'd0);
        check("R1", "full_n", 9'(full_n), 9'd1);
        check("R1", "half_n", 9'(half_n), 9'd1);
        check("R1", "rd_valid", 9'(rd_valid), 9'd0);
        check("R1", "rd_data", rd_data, 9'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // Vector table: R2 R3 R6 R8 R9
        do_reset();
        check_reset();
        for (int i = 0; i < NVEC; i++) begin
            step(VECS[i].wr, VECS[i].wd, VECS[i].rd, VECS[i].rt);
            check("R2 R6 R8 R9 table", "rd_valid", 9'(rd_valid), 9'(VECS[i].ev));
            check("R6 R8 table", "rd_data", rd_data, VECS[i].ed);
            check("R3 table", "empty_n", 9'(empty_n), 9'(VECS[i].ee));
            check("R3 table", "full_n", 9'(full_n), 9'(VECS[i].ef));
            check("R4 table", "half_n", 9'(half_n), 9'(VECS[i].eh));
        end

        // Fill, half-full points, full behaviour
        do_reset();
        check_reset();
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b1, 9'h100 | 9'(i), 1'b0, 1'b0);
            if (i == DEPTH / 2 - 1) check("R4", "half_n at half", 9'(half_n), 9'd1);
            if (i == DEPTH / 2)     check("R4", "half_n above half", 9'(half_n), 9'd0);
            if (i == DEPTH - 2)     check("R3", "full_n one short", 9'(full_n), 9'd1);
        end
        check("R3", "full_n when full", 9'(full_n), 9'd0);
        step(1'b1, 9'h1FF, 1'b0, 1'b0);
        check("R2", "full_n after blocked write", 9'(full_n), 9'd0);
        check("R2", "rd_valid after blocked write", 9'(rd_valid), 9'd0);
        step(1'b1, 9'h155, 1'b1, 1'b0);
        check("R7", "rd_valid on swap", 9'(rd_valid), 9'd1);
        check("R7", "rd_data on swap", rd_data, 9'h100);
        check("R7", "full_n after swap", 9'(full_n), 9'd0);
        for (int k = 1; k <= DEPTH / 2; k++) begin
            step(1'b0, 9'h000, 1'b1, 1'b0);
            check("R8", "read order", rd_data, 9'h100 | 9'(k));
            if (k == DEPTH / 2 - 1) check("R4", "half_n one above half", 9'(half_n), 9'd0);
            if (k == DEPTH / 2)     check("R4", "half_n back at half", 9'(half_n), 9'd1);
        end
        step(1'b0, 9'h000, 1'b0, 1'b0);
        check("R8", "rd_valid idle", 9'(rd_valid), 9'd0);
        check("R8", "rd_data held", rd_data, 9'h100 | 9'(DEPTH / 2));
        for (int k = DEPTH / 2 + 1; k < DEPTH; k++) begin
            step(1'b0, 9'h000, 1'b1, 1'b0);
            check("R8", "read order", rd_data, 9'h100 | 9'(k));
        end
        step(1'b0, 9'h000, 1'b1, 1'b0);
        check("R7", "swapped word last", rd_data, 9'h155);
        check("R2", "blocked write not stored", 9'(empty_n), 9'd0);

        // Rewind with requests held: both ignored
        do_reset();
        for (int i = 0; i < 5; i++) step(1'b1, 9'h0E0 | 9'(i), 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 9'h000, 1'b1, 1'b0);
            check("R8", "pre-rewind read", rd_data, 9'h0E0 | 9'(i));
        end
        step(1'b1, 9'h1EE, 1'b1, 1'b1);
        check("R5", "rd_valid in rewind", 9'(rd_valid), 9'd0);
        check("R5", "empty_n after rewind", 9'(empty_n), 9'd1);
        check("R5", "half_n after rewind", 9'(half_n), 9'd1);
        step(1'b1, 9'h1EF, 1'b1, 1'b0);
        check("R5", "rd_valid in settle cycle", 9'(rd_valid), 9'd0);
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 9'h000, 1'b1, 1'b0);
            check("R5", "replayed word", rd_data, 9'h0E0 | 9'(i));
        end
        check("R5", "no extra words after replay", 9'(empty_n), 9'd0);

        // Rewind on an empty FIFO re-evaluates the flags
        do_reset();
        for (int i = 0; i < 10; i++) step(1'b1, 9'h0C0 | 9'(i), 1'b0, 1'b0);
        check("R4", "half_n with ten words", 9'(half_n), 9'd0);
        for (int i = 0; i < 10; i++) step(1'b0, 9'h000, 1'b1, 1'b0);
        check("R3", "empty_n drained", 9'(empty_n), 9'd0);
        check("R4", "half_n drained", 9'(half_n), 9'd1);
        step(1'b0, 9'h000, 1'b0, 1'b1);
        check("R5", "empty_n recomputed", 9'(empty_n), 9'd1);
        check("R5", "half_n recomputed", 9'(half_n), 9'd0);
        step(1'b0, 9'h000, 1'b0, 1'b0);
        step(1'b0, 9'h000, 1'b1, 1'b0);
        check("R5", "first word after rewind", rd_data, 9'h0C0);
        check("R5", "rd_valid after rewind read", 9'(rd_valid), 9'd1);

        // Reset in the middle of traffic
        do_reset();
        check_reset();

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule